// File: doc/BRIEF.md
# Segmented Host Bus Bridge

This block connects a slow, strobe-driven 16-bit host bus to a set of 64-bit internal resources. The bus has an active-low enable strobe, a read/write select and a command/data select. These inputs are asynchronous to the system clock, so they are synchronized into the clock domain. Edge detection on the synchronized enable marks where each bus cycle starts and ends. At the start of each cycle the block latches the cycle kind and the write word. At the end of each cycle it moves the relevant segment pointer.

Data cycles reach one of four 64-bit resources: the comparand, mask 1, mask 2 or memory. The source and the destination are each chosen separately and stay chosen until changed. Two segment counters walk through the 16-bit slices of a word. Reads slice the chosen source word. Writes emit one 16-bit segment, together with its segment index, towards the chosen destination.

Command writes are passed to an instruction decoder unless they are one of three selection opcodes. Command reads return a status word. A one-shot override redirects the next command cycle to one of four control registers. When the last compared segment of the comparand is written, the block requests a compare.

Top module: `hbus_seg_bridge`

## Requirements
- R1: The synchronized pair {wr_n, cmd_n} selects the cycle kind: 00 is a command write, 01 a data write, 10 a command read and 11 a data read. Suppose a command write arrives with no override pending, and its top nibble is not 1, 2 or 3. Then the block gives exactly one `instr_wr` pulse, and `wr_data` equals the bus word.
- R2: Each write is acted on once, at the falling edge of the enable. It produces exactly one single-cycle strobe, and `wr_data` holds the word that was on the bus during that cycle.
- R3: `dq_oe` is high only during read cycles, and only while the enable is low. While `dq_oe` is low, `dq_o` is zero.
- R4: A data write carries the destination segment counter on `data_seg`. The counter advances when the enable rises. With the comparand as destination it wraps to 0 after `cam_top_seg`; with any other destination it wraps to 0 after segment 3.
- R5: A data read returns bits [16*s+15:16*s] of the selected source word, where s is the source segment counter. Segment 0 is therefore bits 15:0 and segment 3 is bits 63:48. The counter advances when the enable rises and wraps to 0 after segment 3.
- R6: A command write with top nibble 1 selects the persistent source from its bits 1:0 (0 comparand, 1 mask 1, 2 mask 2, 3 memory). It clears the source segment counter and pulses no strobe. The choice holds until the next such command.
- R7: A command write with top nibble 2 selects the persistent destination using the same code. It clears the destination segment counter, and `data_dst` then shows the chosen code.
- R8: A command read with no override pending returns `status_word`.
- R9: A command write with top nibble 3 arms an override for register code bits 1:0 (0 control, 1 segment control, 2 address, 3 next free address). Data cycles leave it armed. The next command cycle consumes it. If that cycle is a write, it gives one `reg_wr` pulse with `reg_sel` set to the code and no `instr_wr` pulse. If it is a read, it returns `reg_words[code]`.
- R10: `cmp_req` pulses together with a data write whose destination is the comparand and whose segment equals `cam_top_seg`. It pulses at no other time.
- R11: After reset the source and destination are the comparand, both segment counters are 0, no override is armed, `dq_oe` is low and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en_n | input | 1 | Host cycle enable, active low |
| bus_wr_n | input | 1 | Host direction, low = write |
| bus_cmd_n | input | 1 | Host kind, low = command |
| dq_i | input | 16 | Host bus write word |
| dq_o | output | 16 | Host bus read word |
| dq_oe | output | 1 | Host bus drive enable |
| cam_top_seg | input | 2 | Highest compared segment of the comparand |
| src_words | input | 4x64 | Words of comparand, mask 1, mask 2, memory |
| status_word | input | 16 | Default command read word |
| reg_words | input | 4x16 | Control register read words |
| wr_data | output | 16 | Word of the most recent write |
| data_wr | output | 1 | Data segment write strobe |
| data_dst | output | 2 | Destination code of the data write |
| data_seg | output | 2 | Segment index of the data write |
| instr_wr | output | 1 | Instruction decoder write strobe |
| reg_wr | output | 1 | Override register write strobe |
| reg_sel | output | 2 | Override register code |
| cmp_req | output | 1 | Automatic compare request |

## Verification
Directed sequences write the comparand with several compared-field widths, which shows whether the compare request falls on the top segment and whether the counter wraps. A comparison against memory writes confirms that the wrap there happens only after segment 3. Reads that run past segment 3 on different sources show whether slices come out in order and whether the source choice is kept. An override armed before data cycles, and then followed by two command reads, shows that the override is used up exactly once and only by a command cycle. A seeded random mix of all seven operation kinds then checks that the state carried between cycles interacts correctly.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  localparam int NRES = 4;

  typedef enum logic [1:0] {
    RES_CMP  = 2'd0,
    RES_MSK1 = 2'd1,
    RES_MSK2 = 2'd2,
    RES_MEM  = 2'd3
  } res_e;

  // encoded as {wr_n, cmd_n}
  typedef enum logic [1:0] {
    CYC_CMD_WR = 2'b00,
    CYC_DAT_WR = 2'b01,
    CYC_CMD_RD = 2'b10,
    CYC_DAT_RD = 2'b11
  } cyc_e;

  localparam logic [3:0] OP_SEL_SRC  = 4'h1;
  localparam logic [3:0] OP_SEL_DST  = 4'h2;
  localparam logic [3:0] OP_OVERRIDE = 4'h3;

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '1;
    else        stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hbus_edge.sv
module hbus_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl;
  end

  assign fall = prev_q & ~lvl;
  assign rise = ~prev_q & lvl;
endmodule

// File: rtl/hbus_seg_ctr.sv
module hbus_seg_ctr #(
  parameter int SEGS = 4,
  localparam int IW  = $clog2(SEGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [IW-1:0] lim,
  output logic [IW-1:0] cnt
);
  logic [IW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = (cnt >= lim) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/hbus_seg_bridge.sv
module hbus_seg_bridge
  import hbus_pkg::*;
#(
  parameter int DQ_W        = 16,
  parameter int SEGS        = 4,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W     = DQ_W * SEGS,
  localparam int SEG_IW     = $clog2(SEGS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_en_n,
  input  logic                         bus_wr_n,
  input  logic                         bus_cmd_n,
  input  logic [DQ_W-1:0]              dq_i,
  output logic [DQ_W-1:0]              dq_o,
  output logic                         dq_oe,
  input  logic [SEG_IW-1:0]            cam_top_seg,
  input  logic [NRES-1:0][WORD_W-1:0]  src_words,
  input  logic [DQ_W-1:0]              status_word,
  input  logic [NRES-1:0][DQ_W-1:0]    reg_words,
  output logic [DQ_W-1:0]              wr_data,
  output logic                         data_wr,
  output logic [1:0]                   data_dst,
  output logic [SEG_IW-1:0]            data_seg,
  output logic                         instr_wr,
  output logic                         reg_wr,
  output logic [1:0]                   reg_sel,
  output logic                         cmp_req
);
  localparam int SYNC_W = DQ_W + 3;

  // synchronized host inputs
  logic [SYNC_W-1:0] sync_q;
  logic              s_en_n;
  logic [DQ_W-1:0]   s_dq;
  cyc_e              cyc_now;
  logic              en_fall, en_rise;

  hbus_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .d({bus_cmd_n, bus_wr_n, dq_i, bus_en_n}),
    .q(sync_q)
  );

  assign s_en_n  = sync_q[0];
  assign s_dq    = sync_q[DQ_W:1];
  assign cyc_now = cyc_e'({sync_q[DQ_W+1], sync_q[DQ_W+2]});

  hbus_edge i_edge (
    .clk(clk), .rst_n(rst_n), .lvl(s_en_n), .fall(en_fall), .rise(en_rise)
  );

  // state
  res_e              src_q, src_d, dst_q, dst_d;
  cyc_e              cyc_q, cyc_d;
  logic              busy_q, busy_d;
  logic              tco_q, tco_d, cyc_tco_q, cyc_tco_d;
  logic [1:0]        tco_sel_q, tco_sel_d;
  logic              oe_q, oe_d;
  logic [DQ_W-1:0]   wdata_q, wdata_d;
  logic              dwr_q, dwr_d, iwr_q, iwr_d, rwr_q, rwr_d, cmp_q, cmp_d;
  logic [1:0]        ddst_q, ddst_d;
  logic [SEG_IW-1:0] dseg_q, dseg_d;

  logic [SEG_IW-1:0] src_cnt, dst_cnt, dst_lim;
  logic              cmd_wr_fall, plain_cmd, dec_sps, dec_spd, dec_tco;
  logic              src_step, dst_step;
  logic [3:0]        op;

  assign op          = s_dq[DQ_W-1 -: 4];
  assign cmd_wr_fall = en_fall && (cyc_now == CYC_CMD_WR);
  assign plain_cmd   = cmd_wr_fall && !tco_q;
  assign dec_sps     = plain_cmd && (op == OP_SEL_SRC);
  assign dec_spd     = plain_cmd && (op == OP_SEL_DST);
  assign dec_tco     = plain_cmd && (op == OP_OVERRIDE);
  assign src_step    = en_rise && busy_q && (cyc_q == CYC_DAT_RD);
  assign dst_step    = en_rise && busy_q && (cyc_q == CYC_DAT_WR);
  assign dst_lim     = (dst_q == RES_CMP) ? cam_top_seg : SEG_IW'(SEGS - 1);

  hbus_seg_ctr #(.SEGS(SEGS)) i_src_ctr (
    .clk(clk), .rst_n(rst_n), .clr(dec_sps), .step(src_step),
    .lim(SEG_IW'(SEGS - 1)), .cnt(src_cnt)
  );

  hbus_seg_ctr #(.SEGS(SEGS)) i_dst_ctr (
    .clk(clk), .rst_n(rst_n), .clr(dec_spd), .step(dst_step),
    .lim(dst_lim), .cnt(dst_cnt)
  );

  // next-state logic
  always_comb begin
    busy_d    = busy_q;
    cyc_d     = cyc_q;
    cyc_tco_d = cyc_tco_q;
    oe_d      = oe_q;
    wdata_d   = wdata_q;
    tco_d     = tco_q;
    tco_sel_d = tco_sel_q;
    src_d     = src_q;
    dst_d     = dst_q;
    if (en_fall) begin
      busy_d    = 1'b1;
      cyc_d     = cyc_now;
      cyc_tco_d = tco_q && !cyc_now[0];
      oe_d      = cyc_now[1];
      if (!cyc_now[1]) wdata_d = s_dq;
    end else if (en_rise) begin
      busy_d = 1'b0;
      oe_d   = 1'b0;
      if (busy_q && cyc_tco_q) tco_d = 1'b0;
    end
    if (dec_tco) begin
      tco_d     = 1'b1;
      tco_sel_d = s_dq[1:0];
    end
    if (dec_sps) src_d = res_e'(s_dq[1:0]);
    if (dec_spd) dst_d = res_e'(s_dq[1:0]);
    dwr_d  = en_fall && (cyc_now == CYC_DAT_WR);
    ddst_d = dst_q;
    dseg_d = dst_cnt;
    cmp_d  = dwr_d && (dst_q == RES_CMP) && (dst_cnt == cam_top_seg);
    iwr_d  = plain_cmd && !(op inside {OP_SEL_SRC, OP_SEL_DST, OP_OVERRIDE});
    rwr_d  = cmd_wr_fall && tco_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cyc_q     <= CYC_DAT_RD;
      cyc_tco_q <= 1'b0;
      oe_q      <= 1'b0;
      wdata_q   <= '0;
      tco_q     <= 1'b0;
      tco_sel_q <= '0;
      src_q     <= RES_CMP;
      dst_q     <= RES_CMP;
      dwr_q     <= 1'b0;
      ddst_q    <= '0;
      dseg_q    <= '0;
      cmp_q     <= 1'b0;
      iwr_q     <= 1'b0;
      rwr_q     <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      cyc_q     <= cyc_d;
      cyc_tco_q <= cyc_tco_d;
      oe_q      <= oe_d;
      wdata_q   <= wdata_d;
      tco_q     <= tco_d;
      tco_sel_q <= tco_sel_d;
      src_q     <= src_d;
      dst_q     <= dst_d;
      dwr_q     <= dwr_d;
      ddst_q    <= ddst_d;
      dseg_q    <= dseg_d;
      cmp_q     <= cmp_d;
      iwr_q     <= iwr_d;
      rwr_q     <= rwr_d;
    end
  end

  // read path: slice each source word into segments
  logic [NRES-1:0][SEGS-1:0][DQ_W-1:0] seg_view;
  for (genvar r = 0; r < NRES; r++) begin : g_res
    for (genvar g = 0; g < SEGS; g++) begin : g_seg
      assign seg_view[r][g] = src_words[r][g*DQ_W +: DQ_W];
    end
  end

  always_comb begin
    dq_o = '0;
    if (oe_q) begin
      if (cyc_q == CYC_DAT_RD) dq_o = seg_view[src_q][src_cnt];
      else if (cyc_tco_q)      dq_o = reg_words[tco_sel_q];
      else                     dq_o = status_word;
    end
  end

  assign dq_oe    = oe_q;
  assign wr_data  = wdata_q;
  assign data_wr  = dwr_q;
  assign data_dst = ddst_q;
  assign data_seg = dseg_q;
  assign instr_wr = iwr_q;
  assign reg_wr   = rwr_q;
  assign reg_sel  = tco_sel_q;
  assign cmp_req  = cmp_q;
endmodule

// File: rtl/hbus_seg_bridge_chk.sv
module hbus_seg_bridge_chk #(
  parameter int DQ_W   = 16,
  parameter int SEG_IW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dq_oe,
  input logic [DQ_W-1:0]   dq_o,
  input logic              data_wr,
  input logic              instr_wr,
  input logic              reg_wr,
  input logic              cmp_req,
  input logic [1:0]        data_dst,
  input logic [SEG_IW-1:0] data_seg,
  input logic [SEG_IW-1:0] cam_top_seg
);
  // R2: at most one kind of write strobe per cycle
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_wr, instr_wr, reg_wr}));

  // R2: a data write strobe lasts one cycle
  a_r2_data_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !data_wr);

  // R9: an override register write lasts one cycle
  a_r9_reg_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R3: no bus drive during a write
  a_r3_no_oe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !(data_wr || instr_wr || reg_wr));

  // R3: quiet bus word when not driven
  a_r3_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_o == '0));

  // R10: compare request only with a top-segment comparand write
  a_r10_cmp_on_top: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req |-> (data_wr && data_dst == 2'd0 && data_seg == cam_top_seg));

  // R4: comparand segment never passes the compared field
  a_r4_cmp_seg_range: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && data_dst == 2'd0) |-> (data_seg <= cam_top_seg));
endmodule

bind hbus_seg_bridge hbus_seg_bridge_chk #(.DQ_W(DQ_W), .SEG_IW(SEG_IW)) i_chk (
  .clk(clk), .rst_n(rst_n), .dq_oe(dq_oe), .dq_o(dq_o),
  .data_wr(data_wr), .instr_wr(instr_wr), .reg_wr(reg_wr), .cmp_req(cmp_req),
  .data_dst(data_dst), .data_seg(data_seg), .cam_top_seg(cam_top_seg)
);

// File: tb/test_hbus_seg_bridge.sv
`timescale 1ns/1ps
module test_hbus_seg_bridge;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_en_n, bus_wr_n, bus_cmd_n;
  logic [15:0]       dq_i, dq_o;
  logic              dq_oe;
  logic [1:0]        cam_top_seg;
  logic [3:0][63:0]  src_words;
  logic [15:0]       status_word;
  logic [3:0][15:0]  reg_words;
  logic [15:0]       wr_data;
  logic              data_wr, instr_wr, reg_wr, cmp_req;
  logic [1:0]        data_dst, data_seg, reg_sel;

  always #2.5 clk = ~clk;

  hbus_seg_bridge i_hbus_seg_bridge (
    .clk(clk), .rst_n(rst_n), .bus_en_n(bus_en_n), .bus_wr_n(bus_wr_n),
    .bus_cmd_n(bus_cmd_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
    .cam_top_seg(cam_top_seg), .src_words(src_words), .status_word(status_word),
    .reg_words(reg_words), .wr_data(wr_data), .data_wr(data_wr),
    .data_dst(data_dst), .data_seg(data_seg), .instr_wr(instr_wr),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .cmp_req(cmp_req)
  );

  int n_chk = 0, n_fail = 0;
  int n_dw = 0, n_iw = 0, n_rw = 0, n_cmp = 0;
  logic [1:0]  l_dst, l_dseg, l_rs;
  logic [15:0] l_wd, l_iw;

  // model state
  logic [1:0] m_src, m_dst, m_scnt, m_dcnt, m_tsel;
  bit         m_tco;

  always @(negedge clk) begin
    if (rst_n) begin
      if (data_wr)  begin n_dw++; l_dst = data_dst; l_dseg = data_seg; l_wd = wr_data; end
      if (cmp_req)  n_cmp++;
      if (instr_wr) begin n_iw++; l_iw = wr_data; end
      if (reg_wr)   begin n_rw++; l_rs = reg_sel; l_wd = wr_data; end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] nxt(input logic [1:0] c, input logic [1:0] lim);
    return (c >= lim) ? 2'd0 : c + 2'd1;
  endfunction

  function automatic logic [15:0] seg_of(input logic [1:0] r, input logic [1:0] s);
    return src_words[r][s*16 +: 16];
  endfunction

  task automatic bus_op(input bit wr_n, input bit cmd_n, input logic [15:0] d,
                        output logic [15:0] rd, output logic oe);
    @(negedge clk);
    bus_wr_n = wr_n; bus_cmd_n = cmd_n; dq_i = d;
    repeat (2) @(negedge clk);
    bus_en_n = 1'b0;
    repeat (6) @(negedge clk);
    rd = dq_o; oe = dq_oe;
    bus_en_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic data_write(input logic [15:0] d);
    int dw0 = n_dw, c0 = n_cmp;
    logic [15:0] rd; logic oe;
    bit exp_cmp = (m_dst == 2'd0) && (m_dcnt == cam_top_seg);
    bus_op(1'b0, 1'b1, d, rd, oe);
    check("R2 data write count", n_dw - dw0, 1);
    check("R2 write word", l_wd, d);
    check("R7 destination code", l_dst, m_dst);
    check("R4 destination segment", l_dseg, m_dcnt);
    check("R10 compare request", n_cmp - c0, exp_cmp);
    check("R3 no drive on write", oe, 0);
    m_dcnt = nxt(m_dcnt, (m_dst == 2'd0) ? cam_top_seg : 2'd3);
  endtask

  task automatic data_read();
    logic [15:0] rd; logic oe;
    bus_op(1'b1, 1'b1, 16'h0, rd, oe);
    check("R5 read segment", rd, seg_of(m_src, m_scnt));
    check("R3 drive on read", oe, 1);
    m_scnt = nxt(m_scnt, 2'd3);
  endtask

  task automatic cmd_write(input logic [15:0] d);
    int dw0 = n_dw, iw0 = n_iw, rw0 = n_rw;
    logic [15:0] rd; logic oe;
    bus_op(1'b0, 1'b0, d, rd, oe);
    check("R2 no data strobe on command", n_dw - dw0, 0);
    check("R3 no drive on command write", oe, 0);
    if (m_tco) begin
      check("R9 override write count", n_rw - rw0, 1);
      check("R9 override register", l_rs, m_tsel);
      check("R9 override word", l_wd, d);
      check("R9 no decoder write", n_iw - iw0, 0);
      m_tco = 0;
    end else begin
      check("R9 no register write", n_rw - rw0, 0);
      case (d[15:12])
        4'h1: begin check("R6 select is silent", n_iw - iw0, 0); m_src = d[1:0]; m_scnt = 0; end
        4'h2: begin check("R7 select is silent", n_iw - iw0, 0); m_dst = d[1:0]; m_dcnt = 0; end
        4'h3: begin check("R9 arm is silent", n_iw - iw0, 0); m_tco = 1; m_tsel = d[1:0]; end
        default: begin
          check("R1 decoder write count", n_iw - iw0, 1);
          check("R1 decoder word", l_iw, d);
        end
      endcase
    end
  endtask

  task automatic cmd_read();
    logic [15:0] rd; logic oe;
    bus_op(1'b1, 1'b0, 16'h0, rd, oe);
    if (m_tco) check("R9 override read", rd, reg_words[m_tsel]);
    else       check("R8 status read", rd, status_word);
    check("R3 drive on command read", oe, 1);
    m_tco = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_en_n = 1'b1; bus_wr_n = 1'b1; bus_cmd_n = 1'b1; dq_i = '0;
    cam_top_seg = 2'd3;
    src_words[0] = 64'h0123_4567_89AB_CDEF;
    src_words[1] = 64'hF0E1_D2C3_B4A5_9687;
    src_words[2] = 64'h1111_2222_3333_4444;
    src_words[3] = 64'hDEAD_BEEF_CAFE_F00D;
    status_word  = 16'h5A5A;
    reg_words    = {16'hD004, 16'hC003, 16'hB002, 16'hA001};
    m_src = 0; m_dst = 0; m_scnt = 0; m_dcnt = 0; m_tco = 0; m_tsel = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 oe after reset", dq_oe, 0);
    check("R11 bus word after reset", dq_o, 0);
    check("R11 strobes after reset", {data_wr, instr_wr, reg_wr, cmp_req}, 0);
    data_read();  // R11: comparand segment 0 by default
    data_read(); data_read(); data_read(); data_read();  // R5 wrap
    // R10/R4: full-width comparand write
    for (int i = 0; i < 5; i++) data_write(16'h1000 + 16'(i));
    // R4: narrow compared field
    cam_top_seg = 2'd1;
    cmd_write(16'h2000);
    for (int i = 0; i < 5; i++) data_write(16'h2100 + 16'(i));
    // R4: memory destination wraps after 3 with no compare
    cmd_write(16'h2003);
    for (int i = 0; i < 5; i++) data_write(16'h3100 + 16'(i));
    // R6: mask 2 source
    cmd_write(16'h1002);
    for (int i = 0; i < 5; i++) data_read();
    // R1 and R8
    cmd_write(16'h7ABC);
    cmd_read();
    // R9: override survives data cycles, consumed once
    cmd_write(16'h3002);
    data_read(); data_write(16'h4444);
    cmd_read();
    cmd_read();
    cmd_write(16'h3001);
    cmd_write(16'hBEEF);
    cmd_write(16'h9876);
    // random mix
    for (int n = 0; n < 300; n++) begin
      int k = $urandom_range(0, 6);
      logic [15:0] w = 16'($urandom);
      case (k)
        0: data_write(w);
        1: data_read();
        2: cmd_write({4'h1, w[11:0]});
        3: cmd_write({4'h2, w[11:0]});
        4: cmd_write({4'h3, w[11:0]});
        5: cmd_write({4'(4 + (w[15:12] % 12)), w[11:0]});
        default: cmd_read();
      endcase
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule